// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wakeup

This block is a relative alarm. Software writes a number of seconds into a load register. While the run bit is set, the current count drops by one on each single-cycle one-second strobe. When the count steps from one down to zero, a sticky pending flag is raised and the count stays at zero. The pending flag reaches two registered outputs: an interrupt line gated by an interrupt-enable bit, and a wakeup line gated by a wakeup-config bit. Software clears the flag by writing 1 to it.

Software accesses the block through a simple register port. A write takes effect in the clock cycle it is presented. A read returns its data one cycle later. To restart a countdown, software writes 0 to the load register, waits briefly, and then writes the new count. A load always overrides any countdown step in the same cycle.

Register map: word address 0 is the load value (read/write). Address 1 is the current count (read only). Addresses 2, 3, 4 and 5 hold, in bit 0, the run bit, the interrupt enable, the pending status and the wakeup config. Addresses 6 and 7 are unused.

Top module: `secs_alarm_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wake_o` are 0.
- R2: A write to address 0 stores the value, which reads back at address 0. It also copies the value into the current count, which reads at address 1.
- R3: The current count drops by exactly one per `tick_i` strobe only while the run bit (address 2, bit 0) is 1. With the run bit at 0, strobes leave the count unchanged.
- R4: A strobe that takes the count from 1 to 0 while running sets pending (address 4, bit 0). Further strobes leave the count at 0.
- R5: A loaded count of 0 never raises pending, however many strobes arrive.
- R6: Writing 1 to address 4, bit 0 clears pending. Writing 0 there leaves pending unchanged.
- R7: `irq_o` equals pending AND interrupt enable (address 3, bit 0), registered one cycle after both are true.
- R8: `wake_o` equals pending AND wakeup config (address 5, bit 0), registered one cycle after both are true.
- R9: When a load write and a strobe land in the same cycle, the load wins, and the count equals the written value.
- R10: Writes to address 1 are ignored. Reads of addresses 6 and 7 return 0.
- R11: When pending is being set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second strobe, high for one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
A wrong count shows up at address 1 on the first read after the faulty strobe. It also shows up as pending rising on the wrong strobe, or never rising. A pending flag that is stuck, or wrongly cleared, is visible at address 4 straight away. It reaches `irq_o` and `wake_o` one cycle later. For that reason, the directed tests read the count after every group of strobes and check both outputs one cycle after each change to pending or to the gating bits. The tests also cover the same-cycle collisions, load against strobe and set against clear, because an error in either ordering is otherwise seen only on rare cycles.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  parameter int unsigned ADR_LOAD = 0;
  parameter int unsigned ADR_CUR  = 1;
  parameter int unsigned ADR_RUN  = 2;
  parameter int unsigned ADR_IEN  = 3;
  parameter int unsigned ADR_STAT = 4;
  parameter int unsigned ADR_WAKE = 5;
endpackage

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cur_val,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step = tick && run && !load_we && (cur_val != '0);
  assign fire = step && (cur_val == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_val <= '0;
      cur_val  <= '0;
    end else if (load_we) begin
      load_val <= load_data;
      cur_val  <= load_data;
    end else if (step) begin
      cur_val  <= cur_val - ONE;
    end
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              set_pend,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [CNT_W-1:0]  cur_val,
  output logic              run_o,
  output logic              ie_o,
  output logic              wk_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= 1'b0;
      ie_o   <= 1'b0;
      wk_o   <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(ADR_RUN))  run_o <= wr_bit;
      if (wr_en && wr_addr == ADDR_W'(ADR_IEN))  ie_o  <= wr_bit;
      if (wr_en && wr_addr == ADDR_W'(ADR_WAKE)) wk_o  <= wr_bit;
      if (set_pend)
        pend_o <= 1'b1;
      else if (wr_en && wr_addr == ADDR_W'(ADR_STAT) && wr_bit)
        pend_o <= 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      ADDR_W'(ADR_LOAD): rd_d[CNT_W-1:0] = load_val;
      ADDR_W'(ADR_CUR):  rd_d[CNT_W-1:0] = cur_val;
      ADDR_W'(ADR_RUN):  rd_d[0] = run_o;
      ADDR_W'(ADR_IEN):  rd_d[0] = ie_o;
      ADDR_W'(ADR_STAT): rd_d[0] = pend_o;
      ADDR_W'(ADR_WAKE): rd_d[0] = wk_o;
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_d;
  end
endmodule

// File: rtl/alarm_outs.sv
module alarm_outs (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic ie,
  input  logic wk,
  output logic irq,
  output logic wake
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= pend & ie;
      wake <= pend & wk;
    end
  end
endmodule

// File: rtl/secs_alarm_timer.sv
module secs_alarm_timer
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic             load_we;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cur_cnt;
  logic             fire;
  logic             run_q, ie_q, wk_q, pend_q;

  assign load_we = wr_en_i && (wr_addr_i == ADDR_W'(ADR_LOAD));

  alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .run(run_q),
    .load_we(load_we), .load_data(wr_data_i[CNT_W-1:0]),
    .load_val(load_val), .cur_val(cur_cnt), .fire(fire)
  );

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_bit(wr_data_i[0]), .rd_en(rd_en_i), .rd_addr(rd_addr_i),
    .set_pend(fire), .load_val(load_val), .cur_val(cur_cnt),
    .run_o(run_q), .ie_o(ie_q), .wk_o(wk_q), .pend_o(pend_q),
    .rd_data_o(rd_data_o)
  );

  alarm_outs u_outs (
    .clk(clk), .rst(rst), .pend(pend_q), .ie(ie_q), .wk(wk_q),
    .irq(irq_o), .wake(wake_o)
  );
endmodule

// File: rtl/alarm_checker.sv
module alarm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             ld_wr,
  input logic [CNT_W-1:0] ld_data,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             ie,
  input logic             wk,
  input logic             irq,
  input logic             wake
);
  p_load_copy_r2: assert property (@(posedge clk) disable iff (rst)
    ld_wr |=> cnt == $past(ld_data));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !ld_wr && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_wr && !(tick && run)) |=> $stable(cnt));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !ld_wr) |=> cnt == '0);

  p_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !ld_wr && cnt == CNT_W'(1)) |=> pend);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (!pend && !(tick && run && !ld_wr && cnt == CNT_W'(1))) |=> !pend);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(pend && ie));

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wake == $past(pend && wk));
endmodule

bind secs_alarm_timer alarm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_i), .run(run_q), .ld_wr(load_we),
  .ld_data(wr_data_i[CNT_W-1:0]), .cnt(cur_cnt), .pend(pend_q),
  .ie(ie_q), .wk(wk_q), .irq(irq_o), .wake(wake_o)
);

// File: tb/secs_alarm_timer_tb.sv
module secs_alarm_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic rd_en_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secs_alarm_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .wake_o(wake_o)
  );

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [DATA_W-1:0] data, bit tk = 1'b0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = ADDR_W'(addr); wr_data_i = data; tick_i = tk;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(int addr, output logic [DATA_W-1:0] val);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = ADDR_W'(addr);
    @(negedge clk);
    rd_en_i = 1'b0;
    val = rd_data_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R1 reg after reset", v, 0);
    end
    check("R1 irq after reset", irq_o, 0);
    check("R1 wake after reset", wake_o, 0);
  endtask

  task automatic t_load();
    logic [DATA_W-1:0] v;
    wr(0, 32'hDEAD_0005);
    rd(0, v); check("R2 load readback", v, 32'hDEAD_0005);
    rd(1, v); check("R2 current copy", v, 32'hDEAD_0005);
    wr(0, 5);
    rd(1, v); check("R2 current copy small", v, 5);
  endtask

  task automatic t_count();
    logic [DATA_W-1:0] v;
    ticks(3);
    rd(1, v); check("R3 ticks ignored when stopped", v, 5);
    wr(2, 1);
    ticks(2);
    rd(1, v); check("R3 two steps", v, 3);
    rd(4, v); check("R4 not pending yet", v, 0);
    ticks(3);
    rd(1, v); check("R4 reached zero", v, 0);
    rd(4, v); check("R4 pending set", v, 1);
    ticks(2);
    rd(1, v); check("R4 holds at zero", v, 0);
    check("R7 irq masked", irq_o, 0);
    check("R8 wake masked", wake_o, 0);
  endtask

  task automatic t_outputs();
    logic [DATA_W-1:0] v;
    wr(3, 1); idle();
    check("R7 irq asserted", irq_o, 1);
    check("R8 wake still masked", wake_o, 0);
    wr(5, 1); idle();
    check("R8 wake asserted", wake_o, 1);
    wr(4, 0);
    rd(4, v); check("R6 write 0 keeps pending", v, 1);
    wr(4, 1);
    rd(4, v); check("R6 write 1 clears pending", v, 0);
    check("R7 irq dropped", irq_o, 0);
    check("R8 wake dropped", wake_o, 0);
  endtask

  task automatic t_zero_load();
    logic [DATA_W-1:0] v;
    wr(0, 0);
    ticks(4);
    rd(4, v); check("R5 zero load no pending", v, 0);
    check("R5 irq low", irq_o, 0);
  endtask

  task automatic t_priority();
    logic [DATA_W-1:0] v;
    wr(0, 10);
    wr(0, 7, 1'b1);
    rd(1, v); check("R9 load beats tick", v, 7);
    ticks(1);
    rd(1, v); check("R3 step after reload", v, 6);
  endtask

  task automatic t_set_clear();
    logic [DATA_W-1:0] v;
    wr(0, 1);
    wr(4, 1, 1'b1);
    rd(4, v); check("R11 set wins over clear", v, 1);
    rd(1, v); check("R4 zero after fire", v, 0);
    wr(4, 1);
  endtask

  task automatic t_unused();
    logic [DATA_W-1:0] v;
    wr(0, 9);
    wr(1, 99);
    rd(1, v); check("R10 current not writable", v, 9);
    rd(6, v); check("R10 unused addr 6", v, 0);
    rd(7, v); check("R10 unused addr 7", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_count();
    t_outputs();
    t_zero_load();
    t_priority();
    t_set_clear();
    t_unused();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule